// File: doc/BRIEF.md
# Programmable Feedback Divider with Per-Period Ratio Offset

This block divides a VCO signal by an integer ratio that may change from one output period to the next. Everything inside it is synchronous to the VCO clock. The ratio is the sum of an unsigned integer part and a small signed offset. In a fractional synthesizer loop, a noise-shaping modulator supplies that offset once per period. Averaged over many periods, the offset sets the fractional part of the division.

The divider is a down-counter whose zero state is captured in a register. That registered pulse drives the synchronous reload. It also serves as the divided output, which goes to the phase detector and clocks the modulator. A second copy of the pulse is brought out as a probe, so the spread of the ratio can be observed. The registered reload adds one state and the count passes through zero, so the counter is loaded with the wanted ratio minus two. A ratio below three cannot be produced, so any sum below three is raised to three.

Top module: `frac_feedback_divider`

## Requirements
- R1: While `rst` is high at a rising edge, `div_out` and `probe_out` go low and the counter is preset from `int_ratio` alone. The offset is ignored and the floor of R5 applies. The first `div_out` pulse is high in the cycle that follows the rising edge (clamped ratio − 1) edges after the last edge with `rst` high.
- R2: Each `div_out` pulse is high for exactly one clock cycle.
- R3: After a pulse, the next pulse begins exactly P rising edges after the edge where the current pulse began. P is `int_ratio + frac_step`, using the input values at the first rising edge inside the current pulse.
- R4: `frac_step` is two's complement and is sign-extended before it is added. The value 4'b1000 means −8 and 4'b0111 means +7.
- R5: When `int_ratio + frac_step` is less than 3, the period is 3 cycles.
- R6: Changes on `int_ratio` and `frac_step` at any other edge have no effect on the period that is running.
- R7: `probe_out` equals `div_out` in every cycle.
- R8: The largest sum, 63 + 7 = 70, gives a 70-cycle period without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO clock; the only clock |
| rst | input | 1 | Synchronous active-high reset |
| int_ratio | input | 6 | Unsigned integer part of the ratio |
| frac_step | input | 4 | Signed per-period offset from the modulator |
| div_out | output | 1 | Divided output; one-cycle reload pulse |
| probe_out | output | 1 | Test copy of the reload pulse |

## Verification
A pulse becomes visible one register after the count reaches zero. The bench therefore samples every output on the falling edge and counts rising edges between pulses. It expects P edges between pulses, and clamped ratio − 1 edges from the last reset edge to the first pulse. New ratio inputs are applied on the falling edge where a pulse is seen, so they are captured at the very next rising edge, which is the reload. Disturbing values are applied one falling edge later; they must leave the running period unchanged. The cycle right after each pulse is checked to be low, and the probe is compared with the output in every cycle.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    // Default widths of the ratio inputs
    localparam int DEF_INT_W  = 6;
    localparam int DEF_STEP_W = 4;

    // Smallest period the counter structure can produce
    localparam int MIN_RATIO   = 3;
    // Registered reload plus the zero state: load = ratio - 2
    localparam int LOAD_OFFSET = 2;

    // Phase of the divider, derived from the reload register
    typedef enum logic {
        PH_COUNT  = 1'b0,
        PH_RELOAD = 1'b1
    } div_phase_e;

    function automatic int max_ratio(input int int_w, input int step_w);
        return (2 ** int_w - 1) + (2 ** (step_w - 1) - 1);
    endfunction

    function automatic int sum_width(input int int_w, input int step_w);
        return ((int_w > step_w) ? int_w : step_w) + 2;
    endfunction

endpackage

// File: rtl/ratio_calc.sv
module ratio_calc
    import frac_div_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int STEP_W = DEF_STEP_W,
    parameter int CNT_W  = 7
) (
    input  logic [INT_W-1:0]  int_part,
    input  logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  load_val
);
    localparam int SUM_W = sum_width(INT_W, STEP_W);
    localparam logic signed [SUM_W-1:0] FLOOR_S = SUM_W'(MIN_RATIO);
    localparam logic signed [SUM_W-1:0] OFFS_S  = SUM_W'(LOAD_OFFSET);

    logic signed [SUM_W-1:0] int_ext;
    logic signed [SUM_W-1:0] step_ext;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] clamped;
    logic signed [SUM_W-1:0] loaded;

    always_comb begin
        int_ext  = {{(SUM_W - INT_W){1'b0}}, int_part};
        step_ext = {{(SUM_W - STEP_W){step[STEP_W-1]}}, step};
        sum      = int_ext + step_ext;
        clamped  = (sum < FLOOR_S) ? FLOOR_S : sum;
        loaded   = clamped - OFFS_S;
        load_val = CNT_W'(loaded);
    end
endmodule

// File: rtl/down_counter.sv
module down_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [CNT_W-1:0] preset_val,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= preset_val;
        else if (load_en)
            cnt <= load_val;
        else
            cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);

    // R3
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cnt == $past(load_val)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/reload_reg.sv
module reload_reg
    import frac_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic at_zero,
    output logic pulse
);
    div_phase_e phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_COUNT;
        else
            phase <= at_zero ? PH_RELOAD : PH_COUNT;
    end

    assign pulse = (phase == PH_RELOAD);

    // R2
    one_wide_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !pulse);
endmodule

// File: rtl/frac_feedback_divider.sv
module frac_feedback_divider
    import frac_div_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int STEP_W = DEF_STEP_W
) (
    input  logic              clk_vco,
    input  logic              rst,
    input  logic [INT_W-1:0]  int_ratio,
    input  logic [STEP_W-1:0] frac_step,
    output logic              div_out,
    output logic              probe_out
);
    localparam int TOP_RATIO = max_ratio(INT_W, STEP_W);
    localparam int CNT_W     = $clog2(TOP_RATIO);

    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] preset_val;
    logic [CNT_W-1:0] cnt;
    logic             at_zero;
    logic             reload;

    ratio_calc #(.INT_W(INT_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_run_calc (
        .int_part (int_ratio),
        .step     (frac_step),
        .load_val (load_val)
    );

    ratio_calc #(.INT_W(INT_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_rst_calc (
        .int_part (int_ratio),
        .step     ('0),
        .load_val (preset_val)
    );

    down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk_vco),
        .rst        (rst),
        .load_en    (reload),
        .preset_val (preset_val),
        .load_val   (load_val),
        .cnt        (cnt),
        .at_zero    (at_zero)
    );

    reload_reg u_reload (
        .clk     (clk_vco),
        .rst     (rst),
        .at_zero (at_zero),
        .pulse   (reload)
    );

    assign div_out   = reload;
    assign probe_out = reload;

    // R5
    min_load_chk: assert property (@(posedge clk_vco) disable iff (rst)
        reload |=> (cnt >= CNT_W'(MIN_RATIO - LOAD_OFFSET)));
endmodule

// File: tb/frac_feedback_divider_tb.sv
module frac_feedback_divider_tb;
    logic       clk_vco = 1'b0;
    logic       rst;
    logic [5:0] int_ratio;
    logic [3:0] frac_step;
    logic       div_out;
    logic       probe_out;

    int checks = 0;
    int errors = 0;

    always #4 clk_vco = ~clk_vco;

    frac_feedback_divider u_dut (
        .clk_vco   (clk_vco),
        .rst       (rst),
        .int_ratio (int_ratio),
        .frac_step (frac_step),
        .div_out   (div_out),
        .probe_out (probe_out)
    );

    function automatic int exp_ratio(input logic [5:0] n, input logic [3:0] d);
        int r;
        r = int'(n) + int'($signed(d));
        if (r < 3) r = 3;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R7: probe mirrors output every cycle
    always @(negedge clk_vco) begin
        if (probe_out !== div_out) begin
            errors++;
            $display("FAIL R7: actual probe %0b expected %0b", probe_out, div_out);
        end
    end

    initial begin
        int expected;
        int gap;
        bit hung;
        logic [5:0] dn [8];
        logic [3:0] dd [8];
        void'($urandom(32'd1234));
        dn[0] = 6'd63; dd[0] = 4'b0111;   // R8: 70
        dn[1] = 6'd0;  dd[1] = 4'b1000;   // R5: -8 -> 3
        dn[2] = 6'd2;  dd[2] = 4'b0000;   // R5: 2 -> 3
        dn[3] = 6'd5;  dd[3] = 4'b1110;   // R4: 3
        dn[4] = 6'd5;  dd[4] = 4'b1101;   // R5: 2 -> 3
        dn[5] = 6'd20; dd[5] = 4'b1000;   // R4: 12
        dn[6] = 6'd20; dd[6] = 4'b0111;   // R4: 27
        dn[7] = 6'd4;  dd[7] = 4'b1111;   // R4: 3
        hung = 1'b0;

        rst = 1'b1; int_ratio = 6'd10; frac_step = 4'b0111;
        repeat (3) @(posedge clk_vco);
        @(negedge clk_vco);
        check("R1 reset div_out", int'(div_out), 0);
        check("R1 reset probe_out", int'(probe_out), 0);
        rst = 1'b0;
        expected = exp_ratio(6'd10, 4'b0000) - 1;   // offset ignored at reset

        for (int p = 0; p < 400 && !hung; p++) begin
            gap = 0;
            do begin
                @(negedge clk_vco);
                gap++;
                if (gap > 200) hung = 1'b1;
            end while (!div_out && !hung);
            if (hung) begin
                errors++;
                $display("FAIL watchdog: actual no pulse expected pulse");
                break;
            end
            if (p == 0) check("R1 first pulse", gap, expected);
            else        check("R3 period", gap, expected);
            // new ratio captured at the next rising edge
            if (p < 8) begin
                int_ratio = dn[p]; frac_step = dd[p];
            end else begin
                int_ratio = 6'($urandom_range(0, 63));
                frac_step = 4'($urandom_range(0, 15));
            end
            expected = exp_ratio(int_ratio, frac_step);
            @(negedge clk_vco);
            check("R2 pulse width", int'(div_out), 0);
            // R6: disturb inputs mid-period; the running period must not change
            if (p % 3 == 0) begin
                int_ratio = 6'($urandom_range(0, 63));
                frac_step = 4'($urandom_range(0, 15));
            end
            // compensate for the extra falling edge already consumed
            expected = expected - 1;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule